// File: doc/BRIEF.md
# Pipelined Q15 Complex Multiplier

This block multiplies two complex numbers whose real and imaginary parts are 16-bit fractional two's complement words (sign at bit 15, weight -1). The X and Y operands are captured in input registers. Each port has its own active-low load enable, and each has a conjugation control that negates the imaginary part as it is captured. Four partial products are formed in parallel and registered. A subtractor and an adder combine them into a 32-bit complex product.

The 32-bit real and imaginary sums pass through a shared scaling shifter selected by a 2-bit code. An optional rounding bit can be forced into the result, and an overflow flag reports a left shift that loses the top bit. An output selector then places two of the four 16-bit halves on the two output ports. The shift code, rounding control and output select are combinational, so the full 64-bit result can be read out as two 32-bit halves while the product register holds still.

Top module: `cplx_q15_mult`

## Requirements
- R1: Each input port loads only on a rising clock edge while its own enable is low. `x_en_n` loads `xr_in` and `xi_in`; `y_en_n` loads `yr_in` and `yi_in`. A port whose enable is high keeps its stored value, whatever its data inputs do.
- R2: The product register updates on every edge from the stored operands. Operands captured at edge k are visible at the outputs after edge k+1 and not before.
- R3: Each partial product is a Q1.30 value in 31 bits. The real sum is XR·YR − XI·YI and the imaginary sum is XR·YI + XI·YR, each held as a 32-bit Q2.30 word.
- R4: A partial product whose two operands are both 0x8000 is replaced by 0x3FFF_FFFF, the largest positive Q1.30 value.
- R5: When `conj_x` is high at a load, XI is stored negated; when `conj_y` is high at a load, YI is stored negated. If both are high, each port is negated independently. Negating 0x8000 gives 0x7FFF.
- R6: `shift_code` scales both sums the same way, combinationally: 2'b00 leaves them unchanged, 2'b11 shifts left by one, 2'b01 shifts right by one arithmetically, and 2'b10 shifts right by two arithmetically.
- R7: `ovf` is high exactly when `shift_code` is 2'b11 and at least one of the two sums has bit 31 different from bit 30.
- R8: When `round_en` is high, bit 16 of both shifted 32-bit results is forced to 1. All other bits are unchanged.
- R9: `out_sel` picks the outputs combinationally. 2'b00 gives p_re = real[31:16] and p_im = imag[31:16]. 2'b01 gives p_re = real[15:0] and p_im = imag[15:0]. 2'b10 gives p_re = real[31:16] and p_im = real[15:0]. 2'b11 gives p_re = imag[31:16] and p_im = imag[15:0].
- R10: While `rst_n` is low, all input and product registers are cleared. With `round_en` low, both outputs and `ovf` then read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xr_in | input | 16 | X real part |
| xi_in | input | 16 | X imaginary part |
| yr_in | input | 16 | Y real part |
| yi_in | input | 16 | Y imaginary part |
| x_en_n | input | 1 | X load enable, active low |
| y_en_n | input | 1 | Y load enable, active low |
| conj_x | input | 1 | Negate X imaginary part at load |
| conj_y | input | 1 | Negate Y imaginary part at load |
| shift_code | input | 2 | Post-sum scaling code |
| round_en | input | 1 | Force bit 16 of the results |
| out_sel | input | 2 | Output half-word selection |
| p_re | output | 16 | First output word |
| p_im | output | 16 | Second output word |
| ovf | output | 1 | Left-shift overflow flag |

## Verification
Each operand set is checked against a 64-bit integer model for all four shift codes, all four selects and both rounding settings. Small fractions such as 0.5 × 0.5 check the bit alignment of the product. Mixed-sign values with odd low bits separate arithmetic right shifts from logical ones and show where the rounding bit lands. Extreme operands built from 0x8000 and 0x7FFF exercise the trap, saturating conjugation and the overflow flag. Sequences that change one port while the other is held, or that sample one edge early, separate independent load enables from a shared one and show the exact pipeline depth.

// File: rtl/cplx_q15_mult.sv
module cplx_q15_mult #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] xr_in,
  input  logic [W-1:0] xi_in,
  input  logic [W-1:0] yr_in,
  input  logic [W-1:0] yi_in,
  input  logic         x_en_n,
  input  logic         y_en_n,
  input  logic         conj_x,
  input  logic         conj_y,
  input  logic [1:0]   shift_code,
  input  logic         round_en,
  input  logic [1:0]   out_sel,
  output logic [W-1:0] p_re,
  output logic [W-1:0] p_im,
  output logic         ovf
);

  localparam int PW = 2*W - 1;
  localparam int SW = 2*W;
  localparam logic [W-1:0]  SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]  SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [PW-1:0] PMAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic [SW-1:0] RBIT = {{(W-1){1'b0}}, 1'b1, {W{1'b0}}};

  function automatic logic [W-1:0] neg_sat(input logic [W-1:0] v);
    return (v == SMIN) ? SMAX : (~v + 1'b1);
  endfunction

  function automatic logic [PW-1:0] mul_trap(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [SW-1:0] full;
    full = $signed(a) * $signed(b);
    return (a == SMIN && b == SMIN) ? PMAX : full[PW-1:0];
  endfunction

  logic [W-1:0]  xr_q, xi_q, yr_q, yi_q;
  logic [PW-1:0] pp_rr, pp_ii, pp_ri, pp_ir;
  logic [SW-1:0] re_sum, im_sum, re_sh, im_sh, re_o, im_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr_q <= '0;
      xi_q <= '0;
    end else if (!x_en_n) begin
      xr_q <= xr_in;
      xi_q <= conj_x ? neg_sat(xi_in) : xi_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yr_q <= '0;
      yi_q <= '0;
    end else if (!y_en_n) begin
      yr_q <= yr_in;
      yi_q <= conj_y ? neg_sat(yi_in) : yi_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_rr <= '0;
      pp_ii <= '0;
      pp_ri <= '0;
      pp_ir <= '0;
    end else begin
      pp_rr <= mul_trap(xr_q, yr_q);
      pp_ii <= mul_trap(xi_q, yi_q);
      pp_ri <= mul_trap(xr_q, yi_q);
      pp_ir <= mul_trap(xi_q, yr_q);
    end
  end

  assign re_sum = {pp_rr[PW-1], pp_rr} - {pp_ii[PW-1], pp_ii};
  assign im_sum = {pp_ri[PW-1], pp_ri} + {pp_ir[PW-1], pp_ir};

  always_comb begin
    case (shift_code)
      2'b11:   begin re_sh = re_sum << 1;                im_sh = im_sum << 1; end
      2'b01:   begin re_sh = $signed(re_sum) >>> 1;      im_sh = $signed(im_sum) >>> 1; end
      2'b10:   begin re_sh = $signed(re_sum) >>> 2;      im_sh = $signed(im_sum) >>> 2; end
      default: begin re_sh = re_sum;                     im_sh = im_sum; end
    endcase
  end

  assign ovf  = (shift_code == 2'b11) &&
                ((re_sum[SW-1] != re_sum[SW-2]) || (im_sum[SW-1] != im_sum[SW-2]));
  assign re_o = round_en ? (re_sh | RBIT) : re_sh;
  assign im_o = round_en ? (im_sh | RBIT) : im_sh;

  always_comb begin
    case (out_sel)
      2'b00:   begin p_re = re_o[SW-1:W]; p_im = im_o[SW-1:W]; end
      2'b01:   begin p_re = re_o[W-1:0];  p_im = im_o[W-1:0];  end
      2'b10:   begin p_re = re_o[SW-1:W]; p_im = re_o[W-1:0];  end
      default: begin p_re = im_o[SW-1:W]; p_im = im_o[W-1:0];  end
    endcase
  end

  assert_x_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    x_en_n |=> ($stable(xr_q) && $stable(xi_q)));
  assert_y_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    y_en_n |=> ($stable(yr_q) && $stable(yi_q)));
  assert_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xr_q == SMIN && yr_q == SMIN) |=> (pp_rr == PMAX));
  assert_conj_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_en_n && conj_x && xi_in == SMIN) |=> (xi_q == SMAX));
  assert_ovf_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (shift_code == 2'b11));
  assert_round_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (round_en && out_sel == 2'b00) |-> (p_re[0] && p_im[0]));

endmodule

// File: tb/sim_cplx_q15_mult.sv
module sim_cplx_q15_mult;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] xr_in = '0, xi_in = '0, yr_in = '0, yi_in = '0;
  logic x_en_n = 1'b1, y_en_n = 1'b1, conj_x = 1'b0, conj_y = 1'b0;
  logic [1:0] shift_code = 2'b00, out_sel = 2'b00;
  logic round_en = 1'b0;
  logic [15:0] p_re, p_im;
  logic ovf;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cplx_q15_mult u0 (.clk(clk), .rst_n(rst_n), .xr_in(xr_in), .xi_in(xi_in),
    .yr_in(yr_in), .yi_in(yi_in), .x_en_n(x_en_n), .y_en_n(y_en_n),
    .conj_x(conj_x), .conj_y(conj_y), .shift_code(shift_code), .round_en(round_en),
    .out_sel(out_sel), .p_re(p_re), .p_im(p_im), .ovf(ovf));

  function automatic longint nsat(longint v);
    return (v == -32768) ? 32767 : -v;
  endfunction

  function automatic longint ppf(longint a, longint b);
    return (a == -32768 && b == -32768) ? 64'sd1073741823 : a * b;
  endfunction

  task automatic model(input logic [15:0] xr, xi, yr, yi, input logic cx, cy,
                       input logic [1:0] sh, sel, input logic rnd,
                       output logic [15:0] er, ei, output logic eo);
    longint ar, ai, br, bi, re, im, rs, is;
    logic [31:0] wr, wi;
    ar = longint'($signed(xr)); ai = longint'($signed(xi));
    br = longint'($signed(yr)); bi = longint'($signed(yi));
    if (cx) ai = nsat(ai);
    if (cy) bi = nsat(bi);
    re = ppf(ar, br) - ppf(ai, bi);
    im = ppf(ar, bi) + ppf(ai, br);
    case (sh)
      2'b11: begin rs = re * 2; is = im * 2; end
      2'b01: begin rs = re >>> 1; is = im >>> 1; end
      2'b10: begin rs = re >>> 2; is = im >>> 2; end
      default: begin rs = re; is = im; end
    endcase
    eo = (sh == 2'b11) && (re > 1073741823 || re < -1073741824 ||
                           im > 1073741823 || im < -1073741824);
    wr = rs[31:0]; wi = is[31:0];
    if (rnd) begin wr[16] = 1'b1; wi[16] = 1'b1; end
    case (sel)
      2'b00: begin er = wr[31:16]; ei = wi[31:16]; end
      2'b01: begin er = wr[15:0];  ei = wi[15:0];  end
      2'b10: begin er = wr[31:16]; ei = wr[15:0];  end
      default: begin er = wi[31:16]; ei = wi[15:0]; end
    endcase
  endtask

  task automatic chk(input string tag, input logic [15:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_both(input logic [15:0] xr, xi, yr, yi, input logic cx, cy);
    @(negedge clk);
    xr_in = xr; xi_in = xi; yr_in = yr; yi_in = yi;
    conj_x = cx; conj_y = cy; x_en_n = 1'b0; y_en_n = 1'b0;
    @(negedge clk);
    x_en_n = 1'b1; y_en_n = 1'b1; conj_x = 1'b0; conj_y = 1'b0;
    xr_in = 16'h5A5A; xi_in = 16'hA5A5; yr_in = 16'h1234; yi_in = 16'hEDCB;
  endtask

  task automatic check_now(input string tag, input logic [15:0] xr, xi, yr, yi, input logic cx, cy);
    logic [15:0] er, ei;
    logic eo;
    model(xr, xi, yr, yi, cx, cy, shift_code, out_sel, round_en, er, ei, eo);
    chk({tag, " p_re"}, p_re, er);
    chk({tag, " p_im"}, p_im, ei);
    chk("R7 ovf", {15'd0, ovf}, {15'd0, eo});
  endtask

  task automatic run_vec(input string tag, input logic [15:0] xr, xi, yr, yi, input logic cx, cy);
    load_both(xr, xi, yr, yi, cx, cy);
    @(negedge clk);
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        for (int r = 0; r < 2; r++) begin
          shift_code = 2'(s); out_sel = 2'(o); round_en = r[0];
          #1;
          check_now(tag, xr, xi, yr, yi, cx, cy);
        end
    shift_code = 2'b00; out_sel = 2'b00; round_en = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R10 reset p_re", p_re, 16'h0000);
    chk("R10 reset p_im", p_im, 16'h0000);
    chk("R10 reset ovf", {15'd0, ovf}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_latency;
    load_both(16'h4000, 16'h0000, 16'h4000, 16'h0000, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    xr_in = 16'h2000; xi_in = 16'h1000; yr_in = 16'hC000; yi_in = 16'h0800;
    x_en_n = 1'b0; y_en_n = 1'b0;
    @(negedge clk);
    x_en_n = 1'b1; y_en_n = 1'b1;
    check_now("R2 early", 16'h4000, 16'h0000, 16'h4000, 16'h0000, 1'b0, 1'b0);
    @(negedge clk);
    check_now("R2 ready", 16'h2000, 16'h1000, 16'hC000, 16'h0800, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    @(negedge clk);
    xr_in = 16'h3000; xi_in = 16'hF000; yr_in = 16'h2800; yi_in = 16'h0C00;
    x_en_n = 1'b0; y_en_n = 1'b0;
    @(negedge clk);
    xr_in = 16'hE000; xi_in = 16'h1800; yr_in = 16'h7FFF; yi_in = 16'h8000;
    x_en_n = 1'b0; y_en_n = 1'b1;
    @(negedge clk);
    x_en_n = 1'b1;
    xr_in = 16'h0001; xi_in = 16'h0002;
    @(negedge clk);
    check_now("R1 y held", 16'hE000, 16'h1800, 16'h2800, 16'h0C00, 1'b0, 1'b0);
    @(negedge clk);
    yr_in = 16'h4000; yi_in = 16'hC000; y_en_n = 1'b0;
    @(negedge clk);
    y_en_n = 1'b1;
    @(negedge clk);
    check_now("R1 x held", 16'hE000, 16'h1800, 16'h4000, 16'hC000, 1'b0, 1'b0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    run_vec("R3 R6 R8 R9 half", 16'h4000, 16'h0000, 16'h4000, 16'h0000, 1'b0, 1'b0);
    run_vec("R3 R6 R8 R9 mixed", 16'hFFFF, 16'h0001, 16'h0003, 16'hFFFD, 1'b0, 1'b0);
    run_vec("R3 R6 R9 generic", 16'h5A3C, 16'hB2E1, 16'h9C07, 16'h3F15, 1'b0, 1'b0);
    run_vec("R4 trap all", 16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b0, 1'b0);
    run_vec("R4 R7 extreme", 16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b0, 1'b0);
    run_vec("R7 max", 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0);
    run_vec("R5 conj x", 16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b1, 1'b0);
    run_vec("R5 conj y", 16'h1234, 16'h4321, 16'h8000, 16'h8000, 1'b0, 1'b1);
    run_vec("R5 conj both", 16'h7FFF, 16'h8000, 16'hC001, 16'h2345, 1'b1, 1'b1);
    t_latency();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule